// File: doc/BRIEF.md
# Dual-Format Time and Calendar Register Set

This block holds the ten byte locations of a real-time clock: the running time (seconds, minutes, hours), the calendar (day of week, date, month, two-digit year) and three alarm holding bytes for seconds, minutes and hours. A one-second tick from an external prescaler advances the time and calendar by one second. A carry ripples up through minutes, hours, day of week, date, month and year. The alarm bytes are only stored; this block does not compare them.

Two mode inputs govern encoding. `bcd_mode` picks pure binary or packed BCD for every byte. `hr24_mode` picks a 24-hour or a 12-hour hours byte; in 12-hour form, bit 7 flags PM. A host reaches every location through a byte-wide write port and a combinational read port. While `set_hold` is high, the host can load a consistent time with no tick landing in the middle. After each applied advance, a one-cycle `upd_done` pulse tells the surrounding logic that fresh values are in place.

Top module: `rtcc_regs`

## Requirements
- R1: Address 0 is seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month and 9 year. A write stores `wr_data` at `addr`, and `rd_data` shows the byte at `addr` in the same cycle. Addresses 10 and above read 0x00, and writes to them change nothing.
- R2: After reset, every location reads 0x00 except day of week, date and month, which read 0x01.
- R3: A tick with `set_hold` low and no write in the same cycle advances seconds by one. `upd_done` is high during exactly the following cycle, and it is low in every other cycle.
- R4: Seconds and minutes count 0 to 59 and then wrap to 0, carrying one upward. With `bcd_mode` = 1 the last value is 0x59; with `bcd_mode` = 0 it is 0x3B.
- R5: With `hr24_mode` = 1, hours count 0 to 23 (0x17 in binary, 0x23 in BCD) and then wrap to 0x00, carrying into the calendar.
- R6: With `hr24_mode` = 0, hours hold 1 to 12 in bits 6..0, and bit 7 = 1 means PM. 11 goes to 12 and flips the PM bit, and 12 goes to 1. Only the step from 11 PM to 12 AM carries into the calendar.
- R7: Day of week counts 1 to 7 on each calendar carry, and 7 wraps to 1.
- R8: Date wraps to 1 after 31, 30, 28 or 29 days, depending on the month. February has 29 days when the year is divisible by four, and year 00 counts as divisible.
- R9: Month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R10: While `set_hold` is 1, a tick changes no location and produces no `upd_done` pulse.
- R11: A host write in the same cycle as a tick is applied, and that tick is dropped entirely.
- R12: The three alarm bytes change only through host writes, never through an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| set_hold | input | 1 | 1 freezes advances while the host loads values |
| bcd_mode | input | 1 | 1 = packed BCD, 0 = binary |
| hr24_mode | input | 1 | 1 = 24-hour hours byte, 0 = 12-hour with PM in bit 7 |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W (4) | Location index for read and write |
| wr_data | input | DATA_W (8) | Byte to store |
| rd_data | output | DATA_W (8) | Byte at `addr` |
| upd_done | output | 1 | One-cycle pulse after an applied advance |

## Verification
The bench builds the block with its default parameters: a year ceiling of 99 and the combinational read variant. With these values, the 99-to-00 year rollover and the leap February of year 00 can be reached in a handful of ticks. The read port also follows the state in the same cycle, so the behavioural model can be compared against the addressed byte and the update pulse on every clock, while a sweep of addresses runs alongside long tick sequences. Each mode combination (binary or BCD, 12-hour or 24-hour) is loaded from scratch under the hold input before it is exercised.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;
   localparam int unsigned LOC_COUNT = 10;

   typedef enum logic [3:0] {
      L_SEC = 4'd0, L_SEC_AL = 4'd1, L_MIN = 4'd2, L_MIN_AL = 4'd3,
      L_HOUR = 4'd4, L_HOUR_AL = 4'd5, L_DOW = 4'd6, L_DATE = 4'd7,
      L_MONTH = 4'd8, L_YEAR = 4'd9
   } loc_e;

   // byte -> plain value under the selected encoding
   function automatic logic [7:0] val_of(input logic [7:0] b, input logic bcd);
      return bcd ? (8'(b[7:4]) * 8'd10 + 8'(b[3:0])) : b;
   endfunction

   // plain value (0..99) -> byte under the selected encoding
   function automatic logic [7:0] byte_of(input logic [7:0] v, input logic bcd);
      return bcd ? {4'(v / 8'd10), 4'(v % 8'd10)} : v;
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'd2:                        return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11:     return 8'd30;
         default:                     return 8'd31;
      endcase
   endfunction

   function automatic logic [7:0] reset_byte(input int unsigned loc);
      return (loc == 6 || loc == 7 || loc == 8) ? 8'h01 : 8'h00;
   endfunction
endpackage

// File: rtl/rtcc_wrap_step.sv
module rtcc_wrap_step
   import rtcc_pkg::*;
(
   input  logic [7:0] cur,
   input  logic       bcd,
   input  logic       en,
   input  logic [7:0] lo,
   input  logic [7:0] hi,
   output logic [7:0] nxt,
   output logic       wrap
);
   logic [7:0] v;

   always_comb begin
      v    = val_of(cur, bcd);
      nxt  = cur;
      wrap = 1'b0;
      if (en) begin
         if (v >= hi) begin
            nxt  = byte_of(lo, bcd);
            wrap = 1'b1;
         end else begin
            nxt  = byte_of(v + 8'd1, bcd);
         end
      end
   end
endmodule

// File: rtl/rtcc_hour_step.sv
module rtcc_hour_step
   import rtcc_pkg::*;
(
   input  logic [7:0] cur,
   input  logic       bcd,
   input  logic       h24,
   input  logic       en,
   output logic [7:0] nxt,
   output logic       day_carry
);
   logic [7:0] v24, v12, e12, e1, inc12, inc24;
   logic       pm;

   always_comb begin
      v24   = val_of(cur, bcd);
      v12   = val_of({1'b0, cur[6:0]}, bcd);
      pm    = cur[7];
      e12   = byte_of(8'd12, bcd);
      e1    = byte_of(8'd1, bcd);
      inc12 = byte_of(v12 + 8'd1, bcd);
      inc24 = byte_of(v24 + 8'd1, bcd);
      nxt       = cur;
      day_carry = 1'b0;
      if (en) begin
         if (h24) begin
            if (v24 >= 8'd23) begin
               nxt       = 8'h00;
               day_carry = 1'b1;
            end else begin
               nxt = inc24;
            end
         end else if (v12 == 8'd11) begin
            nxt       = {~pm, e12[6:0]};
            day_carry = pm;
         end else if (v12 >= 8'd12) begin
            nxt = {pm, e1[6:0]};
         end else begin
            nxt = {pm, inc12[6:0]};
         end
      end
   end
endmodule

// File: rtl/rtcc_regs.sv
module rtcc_regs
   import rtcc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned YEAR_TOP = 99,
   parameter bit          REG_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              set_hold,
   input  logic              bcd_mode,
   input  logic              hr24_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              upd_done
);
   localparam logic [7:0] YEAR_HI = 8'(YEAR_TOP);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("rtcc_regs: DATA_W must be 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("rtcc_regs: ADDR_W must be at least 4");
   end
   if (YEAR_TOP < 1 || YEAR_TOP > 99) begin : g_bad_year
      $error("rtcc_regs: YEAR_TOP must lie in 1..99");
   end

   logic [7:0] loc_q   [LOC_COUNT];
   logic [7:0] loc_nxt [LOC_COUNT];
   logic       do_upd;
   logic       addr_ok;
   logic [7:0] rd_c;

   logic [7:0] sec_n, min_n, hr_n, dow_n, date_n, mon_n, yr_n, mdays;
   logic       sec_w, min_w, day_c, dow_w, date_w, mon_w, yr_w;

   assign do_upd  = tick_1hz && !set_hold && !wr_en;
   assign addr_ok = (addr < ADDR_W'(LOC_COUNT));
   assign mdays   = month_days(val_of(loc_q[L_MONTH], bcd_mode), val_of(loc_q[L_YEAR], bcd_mode));

   rtcc_wrap_step u_sec (.cur(loc_q[L_SEC]), .bcd(bcd_mode), .en(do_upd), .lo(8'd0), .hi(8'd59),
                         .nxt(sec_n), .wrap(sec_w));
   rtcc_wrap_step u_min (.cur(loc_q[L_MIN]), .bcd(bcd_mode), .en(sec_w), .lo(8'd0), .hi(8'd59),
                         .nxt(min_n), .wrap(min_w));
   rtcc_hour_step u_hour (.cur(loc_q[L_HOUR]), .bcd(bcd_mode), .h24(hr24_mode), .en(min_w),
                          .nxt(hr_n), .day_carry(day_c));
   rtcc_wrap_step u_dow (.cur(loc_q[L_DOW]), .bcd(bcd_mode), .en(day_c), .lo(8'd1), .hi(8'd7),
                         .nxt(dow_n), .wrap(dow_w));
   rtcc_wrap_step u_date (.cur(loc_q[L_DATE]), .bcd(bcd_mode), .en(day_c), .lo(8'd1), .hi(mdays),
                          .nxt(date_n), .wrap(date_w));
   rtcc_wrap_step u_mon (.cur(loc_q[L_MONTH]), .bcd(bcd_mode), .en(date_w), .lo(8'd1), .hi(8'd12),
                         .nxt(mon_n), .wrap(mon_w));
   rtcc_wrap_step u_year (.cur(loc_q[L_YEAR]), .bcd(bcd_mode), .en(mon_w), .lo(8'd0), .hi(YEAR_HI),
                          .nxt(yr_n), .wrap(yr_w));

   always_comb begin
      loc_nxt[L_SEC]     = sec_n;
      loc_nxt[L_SEC_AL]  = loc_q[L_SEC_AL];
      loc_nxt[L_MIN]     = min_n;
      loc_nxt[L_MIN_AL]  = loc_q[L_MIN_AL];
      loc_nxt[L_HOUR]    = hr_n;
      loc_nxt[L_HOUR_AL] = loc_q[L_HOUR_AL];
      loc_nxt[L_DOW]     = dow_n;
      loc_nxt[L_DATE]    = date_n;
      loc_nxt[L_MONTH]   = mon_n;
      loc_nxt[L_YEAR]    = yr_n;
   end

   for (genvar g = 0; g < LOC_COUNT; g++) begin : g_loc
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                q <= reset_byte(g);
         else if (wr_en && addr == ADDR_W'(g))      q <= wr_data;
         else if (do_upd)                           q <= loc_nxt[g];
      end
      assign loc_q[g] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) upd_done <= 1'b0;
      else        upd_done <= do_upd;
   end

   assign rd_c = addr_ok ? loc_q[addr[3:0]] : 8'h00;

   if (REG_READ) begin : g_rd_reg
      logic [7:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= 8'h00;
         else        rd_q <= rd_c;
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = rd_c;
   end

   // pulse only after an accepted tick
   assert_upd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> $past(tick_1hz && !set_hold && !wr_en));
   // hold freezes the running seconds byte
   assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hold && !wr_en) |=> $stable(loc_q[L_SEC]));
   // alarm seconds byte moves only on a host write
   assert_alarm_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(L_SEC_AL)) |=> $stable(loc_q[L_SEC_AL]));
   assert_bcd_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_upd && bcd_mode) |=> (loc_q[L_SEC][3:0] <= 4'd9));
   assert_hour12_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (do_upd && !hr24_mode) |=> (loc_q[L_HOUR][6:0] != 7'd0));
   assert_dow_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dow_w |=> (loc_q[L_DOW] == 8'h01));
   assert_year_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      yr_w |=> (loc_q[L_YEAR] == 8'h00));
endmodule

// File: tb/sim_rtcc_regs.sv
`timescale 1ns/1ps
module sim_rtcc_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       set_hold = 1'b0;
   logic       bcd_mode = 1'b1;
   logic       hr24_mode = 1'b1;
   logic       wr_en = 1'b0;
   logic [3:0] addr = 4'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       upd_done;

   always #2.5 clk = ~clk;

   rtcc_regs u0 (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .set_hold(set_hold),
                 .bcd_mode(bcd_mode), .hr24_mode(hr24_mode), .wr_en(wr_en), .addr(addr),
                 .wr_data(wr_data), .rd_data(rd_data), .upd_done(upd_done));

   int checks = 0, fails = 0, cycles = 0;
   string cur_req = "R2";
   // reference state: plain numbers, hours always 0..23
   int s, m, h, dw, dt, mo, yr;
   int al_s, al_m, al_h;
   bit exp_upd;

   function automatic int fdec(int b);
      return bcd_mode ? ((b >> 4) * 10 + (b & 15)) : b;
   endfunction
   function automatic int fenc(int v);
      return bcd_mode ? (((v / 10) << 4) | (v % 10)) : v;
   endfunction
   function automatic int mlen(int mon, int y);
      if (mon == 2) return (y % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction
   function automatic int hour_byte(int hh);
      int h12;
      if (hr24_mode) return fenc(hh);
      h12 = (hh % 12 == 0) ? 12 : hh % 12;
      return ((hh >= 12) ? 128 : 0) | fenc(h12);
   endfunction
   function automatic int hour_from_byte(int b);
      int h12;
      if (hr24_mode) return fdec(b);
      h12 = fdec(b & 127);
      return (h12 % 12) + (((b & 128) != 0) ? 12 : 0);
   endfunction
   function automatic int model_read(int a);
      case (a)
         0: return fenc(s);
         1: return al_s;
         2: return fenc(m);
         3: return al_m;
         4: return hour_byte(h);
         5: return al_h;
         6: return fenc(dw);
         7: return fenc(dt);
         8: return fenc(mo);
         9: return fenc(yr);
         default: return 0;
      endcase
   endfunction

   task automatic model_write(int a, int d);
      case (a)
         0: s = fdec(d);
         1: al_s = d;
         2: m = fdec(d);
         3: al_m = d;
         4: h = hour_from_byte(d);
         5: al_h = d;
         6: dw = fdec(d);
         7: dt = fdec(d);
         8: mo = fdec(d);
         9: yr = fdec(d);
         default: ;
      endcase
   endtask

   task automatic model_advance();
      s++;
      if (s == 60) begin
         s = 0; m++;
         if (m == 60) begin
            m = 0; h++;
            if (h == 24) begin
               h = 0;
               dw = (dw % 7) + 1;
               dt++;
               if (dt > mlen(mo, yr)) begin
                  dt = 1; mo++;
                  if (mo == 13) begin
                     mo = 1;
                     yr = (yr + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic check(string req, int got, int exp, string what);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
      end
   endtask

   // one clock: drive, let the edge happen, update the model, compare
   task automatic cyc(bit tk, bit wr, int a, int d);
      string rq;
      tick_1hz = tk; wr_en = wr; addr = 4'(a); wr_data = 8'(d);
      @(posedge clk);
      exp_upd = 1'b0;
      if (wr) model_write(a, d);
      else if (tk && !set_hold) begin
         model_advance();
         exp_upd = 1'b1;
      end
      #1;
      rq = (a == 1 || a == 3 || a == 5) ? "R12" : cur_req;
      check(rq, rd_data, model_read(a), $sformatf("byte at %0d", a));
      check(cur_req, upd_done, exp_upd, "update pulse");
      tick_1hz = 1'b0; wr_en = 1'b0;
   endtask

   task automatic read_all();
      for (int a = 0; a < 10; a++) cyc(0, 0, a, 0);
   endtask

   // load all ten bytes under hold in the current modes
   task automatic load(int hh, int mm, int ss, int wd, int d, int mon, int y);
      set_hold = 1'b1;
      cyc(0, 1, 0, fenc(ss));
      cyc(0, 1, 2, fenc(mm));
      cyc(0, 1, 4, hour_byte(hh));
      cyc(0, 1, 6, fenc(wd));
      cyc(0, 1, 7, fenc(d));
      cyc(0, 1, 8, fenc(mon));
      cyc(0, 1, 9, fenc(y));
      cyc(0, 1, 1, 8'hC5);
      cyc(0, 1, 3, fenc(30));
      cyc(0, 1, 5, 8'h87);
      set_hold = 1'b0;
   endtask

   task automatic run_ticks(int n);
      for (int i = 0; i < n; i++) cyc(1, 0, i % 10, 0);
      read_all();
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog: got %0d expected below 150000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      s = 0; m = 0; h = 0; dw = 1; dt = 1; mo = 1; yr = 0;
      al_s = 0; al_m = 0; al_h = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      cur_req = "R2"; read_all();

      cur_req = "R1";
      cyc(0, 1, 3, 8'h5A);
      cyc(0, 1, 12, 8'hFF);
      cyc(0, 0, 12, 0);
      cyc(0, 0, 15, 0);
      read_all();

      cur_req = "R3";
      load(10, 20, 30, 3, 15, 6, 24);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      run_ticks(5);

      cur_req = "R4"; bcd_mode = 1'b0;
      load(5, 58, 57, 2, 10, 3, 40);
      run_ticks(130);
      bcd_mode = 1'b1;
      load(5, 58, 57, 2, 10, 3, 40);
      run_ticks(130);

      cur_req = "R5";
      load(23, 59, 58, 4, 12, 5, 30);
      run_ticks(3);
      bcd_mode = 1'b0;
      load(23, 59, 58, 4, 12, 5, 30);
      run_ticks(3);

      cur_req = "R7"; bcd_mode = 1'b1;
      load(23, 59, 59, 7, 20, 7, 11);
      run_ticks(2);

      cur_req = "R9";
      load(23, 59, 58, 6, 31, 12, 99);
      run_ticks(3);
      bcd_mode = 1'b0;
      load(23, 59, 59, 6, 31, 12, 99);
      run_ticks(2);

      cur_req = "R8";
      load(23, 59, 59, 1, 28, 2, 4);   run_ticks(2);
      load(23, 59, 59, 1, 29, 2, 4);   run_ticks(2);
      load(23, 59, 59, 1, 28, 2, 3);   run_ticks(2);
      load(23, 59, 59, 1, 28, 2, 0);   run_ticks(2);
      bcd_mode = 1'b1;
      load(23, 59, 59, 1, 30, 4, 21);  run_ticks(2);
      load(23, 59, 59, 1, 30, 1, 21);  run_ticks(2);
      load(23, 59, 59, 1, 28, 2, 0);   run_ticks(2);

      cur_req = "R6"; hr24_mode = 1'b0;
      load(11, 59, 59, 2, 5, 8, 15);   run_ticks(2);
      load(23, 59, 59, 2, 5, 8, 15);   run_ticks(2);
      load(12, 59, 59, 2, 5, 8, 15);   run_ticks(2);
      load(0, 59, 59, 2, 5, 8, 15);    run_ticks(2);
      bcd_mode = 1'b0;
      load(11, 59, 59, 2, 5, 8, 15);   run_ticks(2);
      load(23, 59, 59, 2, 5, 8, 15);   run_ticks(2);
      load(12, 59, 59, 2, 5, 8, 15);   run_ticks(2);
      bcd_mode = 1'b1;
      load(23, 45, 0, 7, 31, 12, 99);
      run_ticks(1200);

      cur_req = "R10"; hr24_mode = 1'b1;
      load(8, 0, 0, 1, 1, 1, 1);
      set_hold = 1'b1;
      for (int i = 0; i < 20; i++) cyc(1, 0, i % 10, 0);
      set_hold = 1'b0;
      cyc(1, 0, 0, 0);
      read_all();

      cur_req = "R11";
      cyc(1, 1, 0, 8'h30);
      cyc(1, 1, 7, 8'h09);
      cyc(0, 0, 0, 0);
      cyc(1, 0, 0, 0);
      read_all();

      cur_req = "R12";
      load(23, 59, 0, 3, 31, 12, 98);
      run_ticks(200);

      cur_req = "R3";
      load(6, 30, 0, 2, 14, 2, 8);
      run_ticks(4000);

      finish_run();
   end
endmodule